// File: doc/BRIEF.md
# Interrupt Priority Byte Store

This block holds one 8-bit priority for every interrupt of a distributor and serves it over a byte-addressed register window. A register access names the interrupt directly: the byte offset inside the window is the interrupt number. An access is either one byte, touching a single interrupt, or a 32-bit word, touching four interrupts in a row. Every access carries a secure attribute. Together with a disable-security flag and the per-interrupt group bits supplied by a neighbouring block, this attribute decides whether a lane is visible and whether its value passes through a shifted non-secure view.

Read data comes back one cycle after the request, qualified by a valid flag. A separate combinational read port lets a priority arbiter look up any interrupt's raw stored priority. After every accepted write the block pulses an update strobe for one cycle. The strobe carries the first interrupt number and the number of interrupts covered, so that downstream logic can re-evaluate only those interrupts. Arbitration itself sits outside this block.

Top module: `prio_regfile`

## Requirements
- R1: After reset every stored priority is zero, and `rd_valid` and `upd_valid` are low.
- R2: A byte access to offset N addresses interrupt N. A secure byte write stores `acc_wdata[7:0]`. A byte read returns the priority in `rd_data[7:0]` with bits 31:8 zero, and `rd_valid` is high in the cycle after the request.
- R3: Interrupts below FIRST_SPI (32) or at or above NUM_IRQ read as zero. Byte writes to them change nothing and raise no update strobe.
- R4: When `acc_secure`=0 and `sec_disable`=0, a lane whose group bit is 0 reads as zero and ignores writes. A byte write that is in range but blocked this way still raises the strobe.
- R5: A non-secure read (with `sec_disable`=0) of an interrupt whose group bit is 1 returns the stored priority shifted left by one and truncated to 8 bits.
- R6: A non-secure write (with `sec_disable`=0) to an interrupt whose group bit is 1 stores 0x80 OR (data byte shifted right by one).
- R7: With `sec_disable`=1, non-secure accesses see and write raw priorities for every group.
- R8: A word read at offset N (`acc_size`=1) returns interrupt N in bits 7:0, N+1 in 15:8, N+2 in 23:16 and N+3 in 31:24. Each lane is filtered on its own by the range and security rules.
- R9: A word write at offset N stores byte k into interrupt N+k, each lane filtered by security. The whole write is dropped, with no storage change and no strobe, when N < 32 or N+3 >= NUM_IRQ.
- R10: In the cycle after each accepted write, `upd_valid` is high for one cycle with `upd_first` equal to the write offset and `upd_count` equal to 1 for a byte write or 4 for a word write. No strobe follows a read.
- R11: `arb_prio` shows, without delay, the raw stored priority of `arb_idx`. It is zero when `arb_idx` is at or above NUM_IRQ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 1 | 0 = byte, 1 = 32-bit word |
| acc_secure | input | 1 | Secure attribute of the access |
| acc_addr | input | ADDR_W | Byte offset in the window (interrupt number) |
| acc_wdata | input | 32 | Write data, lane k in bits 8k+7:8k |
| sec_disable | input | 1 | Single security state flag |
| group_bits | input | NUM_IRQ | Per-interrupt group, 1 = non-secure group |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| arb_idx | input | ADDR_W | Arbiter lookup index |
| arb_prio | output | 8 | Raw priority of `arb_idx` |
| upd_valid | output | 1 | Update strobe |
| upd_first | output | ADDR_W | First interrupt changed by the write |
| upd_count | output | 3 | Interrupts covered (1 or 4) |

## Verification
The bench targets the edges of the implemented range. A word write at the last fully legal offset must land, and one a byte further must vanish completely. A design that checked only the first lane would corrupt the top interrupts and raise a false strobe. Mixed-group word writes in the non-secure view are checked lane by lane, which catches a design that applies one lane's group decision to all four or forgets to force the top bit. Read-back through both views exposes a swapped shift direction. Blocked byte writes are checked for the strobe that must still follow them, and `sec_disable` is checked for bypassing the shifted view.

// File: rtl/prio_rf_pkg.sv
// Shared types and view transforms for the priority store.
// Assumes priorities are 8 bits and a word access spans four lanes.
package prio_rf_pkg;
    localparam int LANES  = 4;
    localparam int PRIO_W = 8;

    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_WORD = 1'b1
    } acc_size_e;

    // Non-secure view of a stored priority on read.
    function automatic logic [PRIO_W-1:0] ns_rd_view(input logic [PRIO_W-1:0] p);
        return {p[PRIO_W-2:0], 1'b0};
    endfunction

    // Stored value produced by a non-secure write.
    function automatic logic [PRIO_W-1:0] ns_wr_view(input logic [PRIO_W-1:0] v);
        return {1'b1, v[PRIO_W-1:1]};
    endfunction
endpackage

// File: rtl/prio_lane_ctl.sv
// One access lane: range check, security filter and view transform for a
// single interrupt. Assumes the caller supplies the stored byte for the
// lane's index; out-of-range lanes never read or write.
module prio_lane_ctl
    import prio_rf_pkg::*;
#(
    parameter int NUM_IRQ   = 64,
    parameter int FIRST_SPI = 32,
    parameter int ADDR_W    = 10,
    parameter int SIDX_W    = 6
) (
    input  logic [ADDR_W:0]       lane_idx,
    input  logic                  lane_used,
    input  logic                  ns_view,
    input  logic [NUM_IRQ-1:0]    group_bits,
    input  logic [PRIO_W-1:0]     stored,
    input  logic [PRIO_W-1:0]     wbyte,
    output logic                  in_range,
    output logic                  wr_allow,
    output logic [PRIO_W-1:0]     rd_byte,
    output logic [PRIO_W-1:0]     wr_byte,
    output logic [SIDX_W-1:0]     store_idx
);
    localparam logic [ADDR_W:0] LO_L = FIRST_SPI[ADDR_W:0];
    localparam logic [ADDR_W:0] HI_L = NUM_IRQ[ADDR_W:0];

    logic grp;

    // Decide visibility and build the read and write views of this lane.
    always_comb begin
        store_idx = lane_idx[SIDX_W-1:0];
        in_range  = lane_used && (lane_idx >= LO_L) && (lane_idx < HI_L);
        grp       = in_range ? group_bits[store_idx] : 1'b0;
        wr_allow  = in_range && !(ns_view && !grp);
        if (!wr_allow)
            rd_byte = '0;
        else if (ns_view)
            rd_byte = ns_rd_view(stored);
        else
            rd_byte = stored;
        wr_byte = ns_view ? ns_wr_view(wbyte) : wbyte;
    end
endmodule

// File: rtl/prio_store.sv
// Priority storage: one byte per interrupt, up to LANES writes per cycle to
// distinct indices, LANES lane reads and one arbiter read. Assumes writers
// never target the same entry twice in one cycle.
module prio_store
    import prio_rf_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int SIDX_W  = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [LANES-1:0]                  wr_en,
    input  logic [LANES-1:0][SIDX_W-1:0]      wr_idx,
    input  logic [LANES-1:0][PRIO_W-1:0]      wr_val,
    input  logic [LANES-1:0][SIDX_W-1:0]      rd_idx,
    output logic [LANES-1:0][PRIO_W-1:0]      rd_val,
    input  logic [SIDX_W-1:0]                 arb_idx,
    output logic [PRIO_W-1:0]                 arb_val
);
    localparam logic [SIDX_W:0] CNT_L = NUM_IRQ[SIDX_W:0];

    logic [PRIO_W-1:0] mem [NUM_IRQ];

    for (genvar e = 0; e < NUM_IRQ; e++) begin : g_entry
        localparam logic [SIDX_W-1:0] EI = SIDX_W'(e);
        // Load this entry from whichever lane targets it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[e] <= '0;
            end else begin
                for (int l = 0; l < LANES; l++) begin
                    if (wr_en[l] && (wr_idx[l] == EI))
                        mem[e] <= wr_val[l];
                end
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_rd
        // Lane read with a guard for indices past the array.
        always_comb begin
            rd_val[l] = ({1'b0, rd_idx[l]} < CNT_L) ? mem[rd_idx[l]] : '0;
        end
    end

    // Arbiter read, same guard.
    always_comb begin
        arb_val = ({1'b0, arb_idx} < CNT_L) ? mem[arb_idx] : '0;
    end
endmodule

// File: rtl/prio_upd_gen.sv
// Update strobe generator: registers a one-cycle strobe with the first
// interrupt and lane count of an accepted write. Assumes accept is a
// single-cycle qualifier.
module prio_upd_gen
    import prio_rf_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] first,
    input  logic              is_word,
    output logic              upd_valid,
    output logic [ADDR_W-1:0] upd_first,
    output logic [2:0]        upd_count
);
    // Capture the strobe fields for one cycle after an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_valid <= 1'b0;
            upd_first <= '0;
            upd_count <= '0;
        end else begin
            upd_valid <= accept;
            if (accept) begin
                upd_first <= first;
                upd_count <= is_word ? 3'(LANES) : 3'd1;
            end
        end
    end
endmodule

// File: rtl/prio_regfile.sv
// Byte-addressed priority register file. Byte and word accesses, a secure
// attribute with a shifted non-secure view, registered read data, an
// arbiter lookup port and an update strobe. Assumes word accesses are
// issued at offsets the caller considers aligned.
module prio_regfile
    import prio_rf_pkg::*;
#(
    parameter int NUM_IRQ   = 64,
    parameter int FIRST_SPI = 32,
    parameter int ADDR_W    = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic               acc_size,
    input  logic               acc_secure,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [31:0]        acc_wdata,
    input  logic               sec_disable,
    input  logic [NUM_IRQ-1:0] group_bits,
    output logic               rd_valid,
    output logic [31:0]        rd_data,
    input  logic [ADDR_W-1:0]  arb_idx,
    output logic [7:0]         arb_prio,
    output logic               upd_valid,
    output logic [ADDR_W-1:0]  upd_first,
    output logic [2:0]         upd_count
);
    localparam int SIDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
    localparam logic [ADDR_W:0] ARB_HI = NUM_IRQ[ADDR_W:0];

    logic                          is_word;
    logic                          ns_view;
    logic [LANES-1:0]              ln_in_range;
    logic [LANES-1:0]              ln_allow;
    logic [LANES-1:0][PRIO_W-1:0]  ln_rd;
    logic [LANES-1:0][PRIO_W-1:0]  ln_wr;
    logic [LANES-1:0][SIDX_W-1:0]  ln_idx;
    logic [LANES-1:0][PRIO_W-1:0]  ln_stored;
    logic [LANES-1:0]              st_wr_en;
    logic                          range_ok;
    logic                          wr_accept;
    logic [31:0]                   rd_next;
    logic [PRIO_W-1:0]             arb_raw;

    // Access kind and whether the non-secure view applies.
    always_comb begin
        is_word = (acc_size == SZ_WORD);
        ns_view = !acc_secure && !sec_disable;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [ADDR_W:0] idx;
        logic            used;
        // Lane l addresses the interrupt l places after the offset.
        always_comb begin
            idx  = {1'b0, acc_addr} + (ADDR_W+1)'(l);
            used = (l == 0) || is_word;
        end

        prio_lane_ctl #(
            .NUM_IRQ   (NUM_IRQ),
            .FIRST_SPI (FIRST_SPI),
            .ADDR_W    (ADDR_W),
            .SIDX_W    (SIDX_W)
        ) u_lane (
            .lane_idx   (idx),
            .lane_used  (used),
            .ns_view    (ns_view),
            .group_bits (group_bits),
            .stored     (ln_stored[l]),
            .wbyte      (acc_wdata[8*l +: 8]),
            .in_range   (ln_in_range[l]),
            .wr_allow   (ln_allow[l]),
            .rd_byte    (ln_rd[l]),
            .wr_byte    (ln_wr[l]),
            .store_idx  (ln_idx[l])
        );
    end

    // A word is legal only if its first and last lanes are implemented.
    always_comb begin
        range_ok  = is_word ? (ln_in_range[0] && ln_in_range[LANES-1])
                            : ln_in_range[0];
        wr_accept = acc_valid && acc_write && range_ok;
        st_wr_en  = wr_accept ? ln_allow : '0;
        rd_next   = ln_rd;
    end

    prio_store #(
        .NUM_IRQ (NUM_IRQ),
        .SIDX_W  (SIDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (st_wr_en),
        .wr_idx  (ln_idx),
        .wr_val  (ln_wr),
        .rd_idx  (ln_idx),
        .rd_val  (ln_stored),
        .arb_idx (arb_idx[SIDX_W-1:0]),
        .arb_val (arb_raw)
    );

    // Arbiter lookup, zero beyond the implemented count.
    always_comb begin
        arb_prio = ({1'b0, arb_idx} < ARB_HI) ? arb_raw : '0;
    end

    // Register read data one cycle after a read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= acc_valid && !acc_write;
            if (acc_valid && !acc_write)
                rd_data <= rd_next;
        end
    end

    prio_upd_gen #(
        .ADDR_W (ADDR_W)
    ) u_upd (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (wr_accept),
        .first     (acc_addr),
        .is_word   (is_word),
        .upd_valid (upd_valid),
        .upd_first (upd_first),
        .upd_count (upd_count)
    );
endmodule

// File: rtl/prio_regfile_chk.sv
// Protocol checker for prio_regfile, attached with bind. Assumes the
// default FIRST_SPI boundary of the bound instance.
module prio_regfile_chk #(
    parameter int NUM_IRQ   = 64,
    parameter int FIRST_SPI = 32,
    parameter int ADDR_W    = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic              acc_size,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              rd_valid,
    input logic [31:0]       rd_data,
    input logic              upd_valid,
    input logic [ADDR_W-1:0] upd_first,
    input logic [2:0]        upd_count
);
    AST_UPD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> $past(acc_valid && acc_write));   // R10
    AST_UPD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (upd_count == 3'd1 || upd_count == 3'd4));   // R10
    AST_UPD_ABOVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (int'(upd_first) >= FIRST_SPI));   // R3
    AST_WORD_UPD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_count == 3'd4) |-> (int'(upd_first) + 3 < NUM_IRQ));   // R9
    AST_RD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(acc_valid && !acc_write));   // R2
    AST_NO_UPD_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> !upd_valid);   // R10
    AST_BYTE_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && !acc_size) |=> (rd_data[31:8] == 24'd0));   // R2
    AST_LOW_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && !acc_size && int'(acc_addr) < FIRST_SPI)
        |=> (rd_data == 32'd0));   // R3
endmodule

bind prio_regfile prio_regfile_chk #(
    .NUM_IRQ   (NUM_IRQ),
    .FIRST_SPI (FIRST_SPI),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_size  (acc_size),
    .acc_addr  (acc_addr),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .upd_valid (upd_valid),
    .upd_first (upd_first),
    .upd_count (upd_count)
);

// File: tb/prio_regfile_tb.sv
module prio_regfile_tb;
    localparam int NUM_IRQ = 64;
    localparam int FIRST   = 32;
    localparam int ADDR_W  = 10;
    localparam time CLK_P  = 8ns;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               acc_valid = 1'b0;
    logic               acc_write = 1'b0;
    logic               acc_size = 1'b0;
    logic               acc_secure = 1'b1;
    logic [ADDR_W-1:0]  acc_addr = '0;
    logic [31:0]        acc_wdata = '0;
    logic               sec_disable = 1'b0;
    logic [NUM_IRQ-1:0] group_bits = 64'h0F0F_3C3C_0000_0000;
    logic               rd_valid;
    logic [31:0]        rd_data;
    logic [ADDR_W-1:0]  arb_idx = '0;
    logic [7:0]         arb_prio;
    logic               upd_valid;
    logic [ADDR_W-1:0]  upd_first;
    logic [2:0]         upd_count;

    int n_tests = 0;
    int n_fail  = 0;
    bit [7:0] mdl [NUM_IRQ];

    logic [31:0] rd_q[$];
    string       rd_tag_q[$];
    logic [12:0] upd_q[$];

    always #(CLK_P/2) clk = ~clk;

    prio_regfile #(.NUM_IRQ(NUM_IRQ), .FIRST_SPI(FIRST), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_size(acc_size), .acc_secure(acc_secure), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .sec_disable(sec_disable), .group_bits(group_bits),
        .rd_valid(rd_valid), .rd_data(rd_data), .arb_idx(arb_idx), .arb_prio(arb_prio),
        .upd_valid(upd_valid), .upd_first(upd_first), .upd_count(upd_count)
    );

    function automatic bit in_rng(int i);
        return (i >= FIRST) && (i < NUM_IRQ);
    endfunction

    function automatic bit ns_on(bit sec);
        return !sec && !sec_disable;
    endfunction

    function automatic logic [7:0] exp_rd(int i, bit sec);
        if (!in_rng(i)) return 8'h00;
        if (ns_on(sec)) return group_bits[i] ? {mdl[i][6:0], 1'b0} : 8'h00;
        return mdl[i];
    endfunction

    task automatic put_lane(int i, bit sec, logic [7:0] v);
        if (!in_rng(i)) return;
        if (ns_on(sec)) begin
            if (group_bits[i]) mdl[i] = {1'b1, v[7:1]};
        end else begin
            mdl[i] = v;
        end
    endtask

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(bit wr, bit word, bit sec, int addr, logic [31:0] d);
        @(negedge clk);
        acc_valid  = 1'b1;
        acc_write  = wr;
        acc_size   = word;
        acc_secure = sec;
        acc_addr   = ADDR_W'(addr);
        acc_wdata  = d;
        @(posedge clk);
        #1 acc_valid = 1'b0;
    endtask

    // Driver: update the model, queue the strobe, then issue the write.
    task automatic wr_acc(bit word, bit sec, int addr, logic [31:0] d);
        bit ok;
        ok = word ? (in_rng(addr) && in_rng(addr + 3)) : in_rng(addr);
        if (ok) begin
            if (word) for (int k = 0; k < 4; k++) put_lane(addr + k, sec, d[8*k +: 8]);
            else put_lane(addr, sec, d[7:0]);
            upd_q.push_back({word ? 3'd4 : 3'd1, ADDR_W'(addr)});
        end
        drive(1'b1, word, sec, addr, d);
    endtask

    // Driver: queue the expected read word, then issue the read.
    task automatic rd_acc(bit word, bit sec, int addr, string tag);
        logic [31:0] e;
        e = '0;
        if (word) for (int k = 0; k < 4; k++) e[8*k +: 8] = exp_rd(addr + k, sec);
        else e[7:0] = exp_rd(addr, sec);
        rd_q.push_back(e);
        rd_tag_q.push_back(tag);
        drive(1'b0, word, sec, addr, '0);
    endtask

    // Monitor: compare read data and strobes as the design produces them.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid) begin
                if (rd_q.size() == 0) begin
                    check(1'b0, "R2 unexpected rd_valid", rd_data, 0);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = rd_q.pop_front();
                    t = rd_tag_q.pop_front();
                    check(rd_data == e, t, rd_data, e);
                end
            end
            if (upd_valid) begin
                if (upd_q.size() == 0) begin
                    check(1'b0, "R10 unexpected strobe", {upd_count, upd_first}, 0);
                end else begin
                    logic [12:0] u;
                    u = upd_q.pop_front();
                    check({upd_count, upd_first} == u, "R10 strobe fields",
                          {upd_count, upd_first}, u);
                end
            end
        end
    end

    task automatic arb_chk(int i);
        logic [7:0] e;
        arb_idx = ADDR_W'(i);
        #1;
        e = (i < NUM_IRQ) ? mdl[i] : 8'h00;
        check(arb_prio == e, "R11 arbiter lookup", arb_prio, e);
    endtask

    initial begin
        #(CLK_P * 50000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NUM_IRQ; i++) mdl[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rd_valid && !upd_valid, "R1 outputs idle after reset",
              {rd_valid, upd_valid}, 0);
        rd_acc(1'b0, 1'b1, 40, "R1 reset byte zero");
        rd_acc(1'b1, 1'b1, 60, "R1 reset word zero");

        // Secure byte writes and read-back.
        wr_acc(1'b0, 1'b1, 32, 32'h11);
        wr_acc(1'b0, 1'b1, 45, 32'hFFFF_FFA5);
        wr_acc(1'b0, 1'b1, 63, 32'h7E);
        rd_acc(1'b0, 1'b1, 32, "R2 byte read 32");
        rd_acc(1'b0, 1'b1, 45, "R2 byte read 45 upper zero");
        rd_acc(1'b0, 1'b1, 63, "R2 byte read 63");

        // Out of range byte accesses.
        wr_acc(1'b0, 1'b1, 5, 32'h99);
        wr_acc(1'b0, 1'b1, 64, 32'h99);
        rd_acc(1'b0, 1'b1, 5, "R3 low read zero");
        rd_acc(1'b0, 1'b1, 64, "R3 high read zero");
        arb_chk(5);

        // Non-secure view: 32 is group 0, 34 is group 1.
        wr_acc(1'b0, 1'b0, 32, 32'h44);
        rd_acc(1'b0, 1'b1, 32, "R4 blocked write kept value");
        rd_acc(1'b0, 1'b0, 32, "R4 blocked read zero");
        wr_acc(1'b0, 1'b1, 34, 32'hC3);
        rd_acc(1'b0, 1'b0, 34, "R5 shifted read");
        wr_acc(1'b0, 1'b0, 35, 32'h46);
        rd_acc(1'b0, 1'b1, 35, "R6 forced top bit");
        rd_acc(1'b0, 1'b0, 35, "R6 R5 round trip");

        // Security disabled: raw view everywhere.
        sec_disable = 1'b1;
        wr_acc(1'b0, 1'b0, 33, 32'h5A);
        rd_acc(1'b0, 1'b0, 33, "R7 raw non-secure read");
        rd_acc(1'b0, 1'b0, 34, "R7 raw group1 read");
        sec_disable = 1'b0;

        // Word accesses.
        wr_acc(1'b1, 1'b1, 36, 32'hD4C3_B2A1);
        rd_acc(1'b1, 1'b1, 36, "R8 R9 word lane order");
        wr_acc(1'b1, 1'b1, 60, 32'h0403_0201);
        rd_acc(1'b1, 1'b1, 60, "R9 last legal word");
        wr_acc(1'b1, 1'b1, 61, 32'hEEEE_EEEE);
        rd_acc(1'b1, 1'b1, 60, "R9 word past end dropped");
        wr_acc(1'b1, 1'b1, 30, 32'hEEEE_EEEE);
        rd_acc(1'b1, 1'b1, 32, "R9 word below range dropped");
        rd_acc(1'b1, 1'b1, 62, "R8 word read partial range");
        rd_acc(1'b1, 1'b1, 30, "R8 word read straddling low edge");
        wr_acc(1'b1, 1'b0, 40, 32'h8866_4422);
        rd_acc(1'b1, 1'b1, 40, "R9 R4 mixed group word write");
        rd_acc(1'b1, 1'b0, 40, "R8 R5 mixed group word read");

        arb_chk(36);
        arb_chk(41);
        arb_chk(63);
        arb_chk(100);

        repeat (3) @(negedge clk);
        check(rd_q.size() == 0, "R2 all reads returned", rd_q.size(), 0);
        check(upd_q.size() == 0, "R10 all strobes seen", upd_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule